// File: doc/BRIEF.md
# Neighbor-Linked Lane Shuffle Network

This block moves data between the lanes of a SIMD array without a full crossbar. Every lane owns two words, a low slot and a high slot, so an array of `LANES` lanes holds a sequence of `2*LANES` words. Element `k` sits in the low slot of lane `k`, and element `k+LANES` sits in the high slot of lane `k`. A single pulse on `start_i` captures the whole array and the operation code. The block then streams words through a chain of pipeline registers. Each register in the chain talks only to the next one, so each hop costs one cycle.

A multiplexer on the entry side picks the word to feed into the chain on each cycle. On the exit side, the chain contents are written in parallel into the destination lanes' high slots, and later into their low slots. Two operations exist. Broadcast copies one chosen lane's low and high words into every lane. Odd-even grouping reorders the sequence so that all even-indexed elements come first, followed by all odd-indexed elements. The result uses the same lane layout as the input. A one-cycle `done_o` pulse marks the moment the new result is visible.

Top module: `nn_perm_net`

## Requirements
- R1: While reset is active, and on the first cycle after it, `busy_o` and `done_o` are 0 and `lo_o`/`hi_o` are all zeros.
- R2: With `op_i`=1 (grouping), the result sequence is every even-indexed input element in rising order followed by every odd-indexed one. Output position p goes to lane p mod LANES, in the low slot when p < LANES and otherwise in the high slot. For LANES=4 the sequence 0..7 becomes 0 2 4 6 1 3 5 7.
- R3: With `op_i`=0 (broadcast), every lane's low output equals the low input of lane `src_i`, and every high output equals that lane's high input.
- R4: A `start_i` sampled while idle raises `busy_o` at that edge. `busy_o` stays high for 2*LANES+1 cycles. `done_o` is then high for exactly one cycle, in the first cycle with `busy_o` low.
- R5: A `start_i` sampled while `busy_o` is high is ignored: the running operation's result and timing are unchanged.
- R6: `op_i`, `src_i`, `lo_i` and `hi_i` are sampled only at the accepting edge; changes during `busy_o` do not alter the result.
- R7: `lo_o` and `hi_o` change only at the edges of a running operation. While idle they hold their values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| op_i | input | 1 | 1 = odd-even grouping, 0 = broadcast |
| src_i | input | $clog2(LANES) | Source lane for broadcast |
| lo_i | input | LANES*WIDTH | Low-slot words, lane k at bits [k*WIDTH +: WIDTH] |
| hi_i | input | LANES*WIDTH | High-slot words, same packing |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| lo_o | output | LANES*WIDTH | Result low-slot words |
| hi_o | output | LANES*WIDTH | Result high-slot words |

## Verification
The bench builds the block with LANES=4 and WIDTH=8. This is the four-lane, eight-element case whose grouping result and nine-cycle busy window can be checked directly by hand. With four lanes, broadcast from both end lanes and from the interior lanes is reachable. Distinct word values in every slot expose any swap between lanes or between the low and high slots. The four-lane chain is short enough that a start pulse can land at any point inside one busy window.

// File: rtl/nn_perm_net.sv
module nn_perm_net #(
  parameter int LANES = 4,
  parameter int WIDTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     op_i,
  input  logic [$clog2(LANES)-1:0] src_i,
  input  logic [LANES*WIDTH-1:0]   lo_i,
  input  logic [LANES*WIDTH-1:0]   hi_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [LANES*WIDTH-1:0]   lo_o,
  output logic [LANES*WIDTH-1:0]   hi_o
);
  localparam int IW = $clog2(LANES);
  localparam int CW = $clog2(2*LANES+1);
  localparam logic [CW-1:0] HI_CAP = CW'(LANES);
  localparam logic [CW-1:0] LO_CAP = CW'(2*LANES);

  logic [WIDTH-1:0] sl_q [LANES];
  logic [WIDTH-1:0] sh_q [LANES];
  logic [WIDTH-1:0] chain_q [LANES];
  logic [CW-1:0]    cnt_q;
  logic             op_q, busy_q, done_q;
  logic [IW-1:0]    srcl_q;
  logic [LANES*WIDTH-1:0] lo_q, hi_q, chain_flat;

  logic [IW-1:0]    ent_lane;
  logic             ent_hi;
  logic [WIDTH-1:0] ent_word;

  always_comb begin
    int p, e;
    p = (int'(cnt_q) < 2*LANES) ? (2*LANES - 1 - int'(cnt_q)) : 0;
    if (op_q) begin
      e        = (p < LANES) ? 2*p : 2*(p - LANES) + 1;
      ent_hi   = (e >= LANES);
      ent_lane = IW'(ent_hi ? e - LANES : e);
    end else begin
      e        = 0;
      ent_hi   = (p >= LANES);
      ent_lane = srcl_q;
    end
    ent_word = ent_hi ? sh_q[ent_lane] : sl_q[ent_lane];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_flat
    assign chain_flat[k*WIDTH +: WIDTH] = chain_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= 1'b0;
      srcl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      for (int k = 0; k < LANES; k++) begin
        sl_q[k]    <= '0;
        sh_q[k]    <= '0;
        chain_q[k] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          op_q   <= op_i;
          srcl_q <= src_i;
          for (int k = 0; k < LANES; k++) begin
            sl_q[k] <= lo_i[k*WIDTH +: WIDTH];
            sh_q[k] <= hi_i[k*WIDTH +: WIDTH];
          end
        end
      end else begin
        chain_q[0] <= ent_word;
        for (int k = 1; k < LANES; k++) chain_q[k] <= chain_q[k-1];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == HI_CAP) hi_q <= chain_flat;
        if (cnt_q == LO_CAP) begin
          lo_q   <= chain_flat;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
endmodule

// File: rtl/nn_perm_net_chk.sv
module nn_perm_net_chk #(
  parameter int LANES = 4,
  parameter int WIDTH = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic [LANES*WIDTH-1:0] lo_o,
  input logic [LANES*WIDTH-1:0] hi_o
);
  localparam int CW = $clog2(2*LANES+2) + 1;
  localparam logic [CW-1:0] SPAN = CW'(2*LANES+1);
  logic [CW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else if (!busy_o && start_i) win_q <= '0;
    else if (busy_o) win_q <= win_q + 1'b1;
  end

  p_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_done_span_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (win_q == SPAN));
  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  p_restart_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && win_q < SPAN - 1'b1) |=> busy_o);
  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(lo_o) && $stable(hi_o)));
endmodule

bind nn_perm_net nn_perm_net_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .lo_o(lo_o), .hi_o(hi_o)
);

// File: tb/tb_nn_perm_net.sv
module tb_nn_perm_net;
  localparam int LANES = 4;
  localparam int WIDTH = 8;
  localparam int TCLK  = 10;
  localparam int VW    = LANES*WIDTH;
  localparam int NV    = 7;
  localparam int LAT   = 2*LANES + 2;

  // {op, src, hi, lo}
  localparam logic [2*VW+2:0] VEC [NV] = '{
    {1'b1, 2'd0, 32'h07060504, 32'h03020100},
    {1'b1, 2'd2, 32'hF1E2D3C4, 32'hB5A69788},
    {1'b0, 2'd0, 32'h18171615, 32'h14131211},
    {1'b0, 2'd3, 32'h28272625, 32'h24232221},
    {1'b0, 2'd1, 32'hA0B0C0D0, 32'h0A0B0C0D},
    {1'b1, 2'd1, 32'h00FF00FF, 32'h55AA33CC},
    {1'b0, 2'd2, 32'h9F8E7D6C, 32'h5B4A3928}
  };

  logic clk = 0, rst_n = 0, start = 0, op = 0;
  logic [1:0] src = 0;
  logic [VW-1:0] lo_in = 0, hi_in = 0, lo_out, hi_out;
  logic busy, done;
  int checks = 0, errors = 0;

  always #(TCLK/2) clk = ~clk;

  nn_perm_net #(.LANES(LANES), .WIDTH(WIDTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .src_i(src),
    .lo_i(lo_in), .hi_i(hi_in), .busy_o(busy), .done_o(done),
    .lo_o(lo_out), .hi_o(hi_out));

  task automatic chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void expect_of(input logic o, input logic [1:0] s,
      input logic [VW-1:0] l, input logic [VW-1:0] h,
      output logic [VW-1:0] el, output logic [VW-1:0] eh);
    logic [WIDTH-1:0] seq [2*LANES];
    logic [WIDTH-1:0] res [2*LANES];
    int n = 0;
    for (int i = 0; i < LANES; i++) begin
      seq[i] = l[i*WIDTH +: WIDTH];
      seq[i+LANES] = h[i*WIDTH +: WIDTH];
    end
    for (int e = 0; e < 2*LANES; e += 2) begin res[n] = seq[e]; n++; end
    for (int e = 1; e < 2*LANES; e += 2) begin res[n] = seq[e]; n++; end
    for (int k = 0; k < LANES; k++) begin
      el[k*WIDTH +: WIDTH] = o ? res[k] : seq[s];
      eh[k*WIDTH +: WIDTH] = o ? res[k+LANES] : seq[int'(s)+LANES];
    end
  endfunction

  // mode 0: plain, 1: extra start during busy, 2: inputs change during busy
  task automatic run(input logic o, input logic [1:0] s, input logic [VW-1:0] l,
      input logic [VW-1:0] h, input int mode, output int lat);
    @(negedge clk);
    op = o; src = s; lo_in = l; hi_in = h; start = 1;
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done && lat < 100) begin
      if (lat == 3 && mode != 0) begin
        op = ~o; src = s + 2'd1; lo_in = ~l; hi_in = l ^ h;
        start = (mode == 1);
      end
      if (lat == 4) start = 0;
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin : watchdog
    #(TCLK*20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [VW-1:0] el, eh;
    int lat;
    #(TCLK*2 + 3);
    // R1 during reset
    chk("R1 busy", {31'b0, busy}, '0);
    chk("R1 lo", lo_out, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done", {31'b0, done}, '0);
    chk("R1 hi", hi_out, '0);

    for (int i = 0; i < NV; i++) begin
      logic [2*VW+2:0] v;
      v = VEC[i];
      run(v[2*VW+2], v[2*VW+1:2*VW], v[VW-1:0], v[2*VW-1:VW], 0, lat);
      expect_of(v[2*VW+2], v[2*VW+1:2*VW], v[VW-1:0], v[2*VW-1:VW], el, eh);
      chk(v[2*VW+2] ? "R2 lo" : "R3 lo", lo_out, el);
      chk(v[2*VW+2] ? "R2 hi" : "R3 hi", hi_out, eh);
      chk("R4 latency", VW'(lat), VW'(LAT));
      chk("R4 busy low at done", {31'b0, busy}, '0);
      @(negedge clk);
      chk("R4 done single", {31'b0, done}, '0);
    end

    // R5: restart request while busy is ignored
    run(1'b1, 2'd0, 32'h13579BDF, 32'h2468ACE0, 1, lat);
    expect_of(1'b1, 2'd0, 32'h13579BDF, 32'h2468ACE0, el, eh);
    chk("R5 lo", lo_out, el);
    chk("R5 hi", hi_out, eh);
    chk("R5 latency", VW'(lat), VW'(LAT));
    @(negedge clk);
    chk("R5 no second run", {31'b0, busy}, '0);

    // R6: inputs disturbed during busy
    run(1'b0, 2'd3, 32'hDEADBEEF, 32'hCAFEF00D, 2, lat);
    expect_of(1'b0, 2'd3, 32'hDEADBEEF, 32'hCAFEF00D, el, eh);
    chk("R6 lo", lo_out, el);
    chk("R6 hi", hi_out, eh);

    // R7: hold while idle with inputs toggling
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      lo_in = lo_in + 32'h01010101; hi_in = ~hi_in; op = ~op; src = src + 2'd1;
    end
    @(negedge clk);
    chk("R7 lo hold", lo_out, el);
    chk("R7 hi hold", hi_out, eh);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule